// File: doc/BRIEF.md
# Video Control Register Bank with I2C Slave Port

This block is the serial control port of a television video processor. An I2C master addresses it at the fixed 7-bit device address 1011101. In a write transfer the master sends a subaddress and then one data byte. That byte lands in one of 29 eight-bit control registers. Each register starts from its own reset value. The register contents leave the block as one flat parallel bus. Two settings are also decoded: a luminance mute and a regional demodulation mode.

A read transfer returns a single status byte. The byte packs live detector flags, all active-low in sense, into fixed bit positions. The flags are frozen into a shadow register while the read address is acknowledged, so the byte cannot change while it is being shifted out.

SCL and SDA are sampled by the system clock through a synchronizer. The block pulls SDA low through `sda_oe_o`, and the pad is open-drain. The block does not stretch the clock.

Top module: `vid_ctl_i2c_bank`

## Requirements
- R1: After reset, every control register holds its default and all other registers hold 00h. The defaults are: 04h=20h, 05h/07h/08h/17h=40h, 06h=80h, 09h=04h, 0Ah..0Fh=80h, 10h=24h, 11h=20h, 14h=03h, 16h=90h, 1Ch=04h. SDA is released.
- R2: A write transfer works as follows: START, address byte BAh (address 1011101, R/W=0), subaddress, data. The block ACKs each of the three bytes, and the register at that subaddress takes the data byte.
- R3: An address byte other than BAh or BBh is NACKed, and the transfer changes no register.
- R4: A subaddress above 1Ch is NACKed. The data byte that follows is NACKed and written nowhere. Subaddress 1Ch itself is accepted.
- R5: A read (address byte BBh) returns the status byte with these bits: D7 = killer-off flag, D6 = FM not detected, D5 = vertical not locked, D4 = standard not detected, D3 = AFT0, D2 = AFT1, D1 = horizontal not locked, D0 = 0. If the master ACKs, the same byte is sent again. A NACK ends the read.
- R6: The status flags are captured when the read address byte is acknowledged. A flag change after that point does not alter the byte being shifted out, but the next read reflects it.
- R7: `luma_mute_o` equals bit 7 of register 02h.
- R8: The field made of bits 3:1 of register 15h selects the region. Value 100 asserts `region_us_o` and value 011 asserts `region_jpn_o`. Any other value asserts neither.
- R9: SDA drive changes only while SCL is low, and SDA is released while the bus is idle.
- R10: Any byte after the data byte in the same transfer is NACKed and writes nothing.
- R11: A register changes only when a complete data byte has been received. A STOP in the middle of a byte leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line |
| sda_i | input | 1 | I2C data line as seen on the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain) |
| killer_off_i | input | 1 | Colour killer off flag |
| fm_nodet_i | input | 1 | FM radio not detected |
| v_unlock_i | input | 1 | Vertical sync not locked |
| std_nodet_i | input | 1 | Standard not detected |
| aft0_i | input | 1 | AFT information bit 0 |
| aft1_i | input | 1 | AFT information bit 1 |
| h_unlock_i | input | 1 | Horizontal sync not locked |
| ctrl_o | output | NREG*8 | All registers, register n at bits [8n+7:8n] |
| luma_mute_o | output | 1 | Luminance mute control |
| region_us_o | output | 1 | US regional mode selected |
| region_jpn_o | output | 1 | JPN regional mode selected |

## Verification
The bench targets the edges of the subaddress range. It writes 1Ch and then tries 1Dh. A design with an off-by-one compare would either refuse the last register or write through a stray index.

The bench changes the status flags in the middle of a read. A design that sends the live flags instead of a captured copy would return a mixed byte.

The bench also sends extra bytes after a complete write, and it aborts a data byte with a STOP. A design that auto-increments, or writes partly shifted data, would corrupt a neighbouring register. Both regional field codes are checked, along with a code that matches neither, to catch a decoder that looks at only one bit.

// File: rtl/vcb_pkg.sv
package vcb_pkg;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_SUB, PH_DATA, PH_SKIP, PH_READ
  } phase_e;

  // Power-up value of each control register
  function automatic logic [7:0] reg_default(input int idx);
    case (idx)
      32'h04, 32'h11:                 reg_default = 8'h20;
      32'h05, 32'h07, 32'h08, 32'h17: reg_default = 8'h40;
      32'h06:                         reg_default = 8'h80;
      32'h09, 32'h1C:                 reg_default = 8'h04;
      32'h0A, 32'h0B, 32'h0C,
      32'h0D, 32'h0E, 32'h0F:         reg_default = 8'h80;
      32'h10:                         reg_default = 8'h24;
      32'h14:                         reg_default = 8'h03;
      32'h16:                         reg_default = 8'h90;
      default:                        reg_default = 8'h00;
    endcase
  endfunction

  // Status byte assembly; bit 0 is always zero
  function automatic logic [7:0] pack_status(
    input logic killer_off, input logic fm_nodet, input logic v_unlock,
    input logic std_nodet, input logic aft0, input logic aft1,
    input logic h_unlock);
    pack_status = {killer_off, fm_nodet, v_unlock, std_nodet,
                   aft0, aft1, h_unlock, 1'b0};
  endfunction

endpackage

// File: rtl/vcb_line_sync.sv
module vcb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES:0] scl_pipe, sda_pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-1:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-1:0], sda_i};
    end
  end

  logic scl_p, sda_p;
  assign scl_s = scl_pipe[STAGES-1];
  assign sda_s = sda_pipe[STAGES-1];
  assign scl_p = scl_pipe[STAGES];
  assign sda_p = sda_pipe[STAGES];

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/vcb_i2c_engine.sv
module vcb_i2c_engine
  import vcb_pkg::*;
#(
  parameter int          NREG     = 29,
  parameter logic [6:0]  DEV_ADDR = 7'h5D,
  localparam int         AW       = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          sda_s,
  input  logic [7:0]    status_now,
  output logic          sda_oe,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic [7:0]    shadow,
  output logic          byte_done,
  output logic          shadow_ld,
  output logic          rd_active,
  output logic          bus_idle
);
  phase_e       ph, ph_next;
  logic [3:0]   cnt;
  logic [7:0]   sh, tx;
  logic         in_ack, ack_drv, m_ack, accept;
  logic [AW-1:0] sub;

  logic receiving;
  assign receiving = (ph == PH_ADDR) || (ph == PH_SUB) ||
                     (ph == PH_DATA) || (ph == PH_SKIP);
  assign byte_done = scl_fall && !in_ack && receiving && (cnt == 4'd8);

  always_comb begin
    accept  = 1'b0;
    ph_next = ph;
    case (ph)
      PH_ADDR: begin
        accept  = (sh[7:1] == DEV_ADDR);
        ph_next = !accept ? PH_IDLE : (sh[0] ? PH_READ : PH_SUB);
      end
      PH_SUB: begin
        accept  = (int'(sh) <= NREG - 1);
        ph_next = accept ? PH_DATA : PH_SKIP;
      end
      PH_DATA: begin
        accept  = 1'b1;
        ph_next = PH_SKIP;
      end
      default: begin
        accept  = 1'b0;
        ph_next = ph;
      end
    endcase
  end

  assign shadow_ld = byte_done && (ph == PH_ADDR) && (sh == {DEV_ADDR, 1'b1});
  assign wr_en     = byte_done && (ph == PH_DATA);
  assign wr_addr   = sub;
  assign wr_data   = sh;
  assign rd_active = (ph == PH_READ);
  assign bus_idle  = (ph == PH_IDLE);
  assign sda_oe    = ack_drv | (rd_active && !in_ack && (cnt < 4'd8) && !tx[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_IDLE; cnt <= '0; sh <= '0; tx <= '0; shadow <= '0;
      in_ack <= 1'b0; ack_drv <= 1'b0; m_ack <= 1'b0; sub <= '0;
    end else if (start_det || stop_det) begin
      ph      <= start_det ? PH_ADDR : PH_IDLE;
      cnt     <= '0;
      in_ack  <= 1'b0;
      ack_drv <= 1'b0;
    end else if (in_ack) begin
      if (scl_fall) begin
        in_ack  <= 1'b0;
        ack_drv <= 1'b0;
        cnt     <= '0;
        if (ph == PH_READ) tx <= shadow;
      end
    end else if (receiving) begin
      if (scl_rise && cnt < 4'd8) begin
        sh  <= {sh[6:0], sda_s};
        cnt <= cnt + 4'd1;
      end
      if (byte_done) begin
        in_ack  <= 1'b1;
        ack_drv <= accept;
        ph      <= ph_next;
        if (ph == PH_SUB && accept) sub <= sh[AW-1:0];
        if (shadow_ld) shadow <= status_now;
      end
    end else if (ph == PH_READ) begin
      if (scl_rise && cnt == 4'd8) m_ack <= ~sda_s;
      if (scl_fall) begin
        if (cnt < 4'd7) begin
          tx  <= {tx[6:0], 1'b0};
          cnt <= cnt + 4'd1;
        end else if (cnt == 4'd7) begin
          cnt <= 4'd8;
        end else if (m_ack) begin
          tx  <= shadow;
          cnt <= '0;
        end else begin
          ph <= PH_IDLE;
        end
      end
    end
  end
endmodule

// File: rtl/vcb_reg_bank.sv
module vcb_reg_bank
  import vcb_pkg::*;
#(
  parameter  int NREG = 29,
  localparam int AW   = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [7:0]        wr_data,
  output logic [NREG*8-1:0] ctrl
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ctrl[g*8 +: 8] <= reg_default(g);
      else if (wr_en && wr_addr == AW'(g))
        ctrl[g*8 +: 8] <= wr_data;
    end
  end
endmodule

// File: rtl/vid_ctl_i2c_bank.sv
module vid_ctl_i2c_bank
  import vcb_pkg::*;
#(
  parameter int         NREG        = 29,
  parameter logic [6:0] DEV_ADDR    = 7'h5D,
  parameter int         SYNC_STAGES = 2,
  parameter int         MUTE_REG    = 2,
  parameter int         REGION_REG  = 21,
  localparam int        AW          = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              killer_off_i,
  input  logic              fm_nodet_i,
  input  logic              v_unlock_i,
  input  logic              std_nodet_i,
  input  logic              aft0_i,
  input  logic              aft1_i,
  input  logic              h_unlock_i,
  output logic [NREG*8-1:0] ctrl_o,
  output logic              luma_mute_o,
  output logic              region_us_o,
  output logic              region_jpn_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en, byte_done, shadow_ld, rd_active, bus_idle;
  logic [AW-1:0] wr_addr;
  logic [7:0] wr_data, shadow, status_now;
  logic [2:0] region_field;

  assign status_now = pack_status(killer_off_i, fm_nodet_i, v_unlock_i,
                                  std_nodet_i, aft0_i, aft1_i, h_unlock_i);

  vcb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det));

  vcb_i2c_engine #(.NREG(NREG), .DEV_ADDR(DEV_ADDR)) u_eng (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
    .status_now(status_now), .sda_oe(sda_oe_o), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .shadow(shadow),
    .byte_done(byte_done), .shadow_ld(shadow_ld), .rd_active(rd_active),
    .bus_idle(bus_idle));

  vcb_reg_bank #(.NREG(NREG)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl(ctrl_o));

  assign luma_mute_o  = ctrl_o[MUTE_REG*8 + 7];
  assign region_field = ctrl_o[REGION_REG*8 + 1 +: 3];
  assign region_us_o  = (region_field == 3'b100);
  assign region_jpn_o = (region_field == 3'b011);
endmodule

// File: rtl/vcb_checker.sv
module vcb_checker #(
  parameter  int NREG = 29,
  localparam int AW   = $clog2(NREG)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              sda_oe,
  input logic              wr_en,
  input logic [AW-1:0]     wr_addr,
  input logic              shadow_ld,
  input logic              rd_active,
  input logic              bus_idle,
  input logic [7:0]        shadow,
  input logic [NREG*8-1:0] ctrl
);
  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s); // R9
  AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_idle |-> !sda_oe); // R9
  AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_addr) <= NREG - 1)); // R4
  AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl)); // R11
  AST_SHADOW_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_active && !shadow_ld) |=> $stable(shadow)); // R6
endmodule

bind vid_ctl_i2c_bank vcb_checker #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe_o),
  .wr_en(wr_en), .wr_addr(wr_addr), .shadow_ld(shadow_ld),
  .rd_active(rd_active), .bus_idle(bus_idle), .shadow(shadow),
  .ctrl(ctrl_o));

// File: tb/vid_ctl_i2c_bank_tb.sv
module vid_ctl_i2c_bank_tb;
  localparam int NREG = 29;
  localparam int Q    = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic k_off = 0, fm_nd = 0, v_ul = 0, std_nd = 0, a0 = 0, a1 = 0, h_ul = 0;
  logic [NREG*8-1:0] ctrl;
  logic mute, r_us, r_jpn;
  wire  sda_line = sda_m & ~sda_oe;

  int tests = 0, fails = 0;
  logic done = 1'b0;
  logic [7:0] exp_reg [NREG];

  always #10 clk = ~clk;

  vid_ctl_i2c_bank u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .killer_off_i(k_off), .fm_nodet_i(fm_nd), .v_unlock_i(v_ul),
    .std_nodet_i(std_nd), .aft0_i(a0), .aft1_i(a1), .h_unlock_i(h_ul),
    .ctrl_o(ctrl), .luma_mute_o(mute), .region_us_o(r_us), .region_jpn_o(r_jpn));

  function automatic logic [7:0] dflt(input int i);
    if (i == 4 || i == 17) return 8'h20;
    if (i == 5 || i == 7 || i == 8 || i == 23) return 8'h40;
    if (i == 6 || (i >= 10 && i <= 15)) return 8'h80;
    if (i == 9 || i == 28) return 8'h04;
    if (i == 16) return 8'h24;
    if (i == 20) return 8'h03;
    if (i == 22) return 8'h90;
    return 8'h00;
  endfunction

  function automatic logic [7:0] exp_status();
    return {k_off, fm_nd, v_ul, std_nd, a0, a1, h_ul, 1'b0};
  endfunction

  task automatic q(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_regs(input string req);
    int bad = 0;
    for (int i = 0; i < NREG; i++)
      if (ctrl[i*8 +: 8] !== exp_reg[i]) begin
        bad++;
        $display("FAIL %s: reg %0h actual %h expected %h", req, i, ctrl[i*8 +: 8], exp_reg[i]);
      end
    tests++;
    if (bad != 0) fails++;
  endtask

  task automatic i2c_start();
    sda_m = 1; q(1); scl = 1; q(1); sda_m = 0; q(1); scl = 0; q(1);
  endtask

  task automatic i2c_stop();
    sda_m = 0; q(1); scl = 1; q(1); sda_m = 1; q(2);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; q(1); scl = 1; q(2); scl = 0; q(1);
    end
    sda_m = 1; q(1); scl = 1; q(1); ack = ~sda_line; q(1); scl = 0; q(1);
  endtask

  task automatic rbyte(input logic m_ack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      q(1); scl = 1; q(1); b[i] = sda_line; q(1); scl = 0; q(1);
    end
    sda_m = ~m_ack; q(1); scl = 1; q(2); scl = 0; q(1); sda_m = 1;
  endtask

  task automatic wr_reg(input logic [7:0] sub, input logic [7:0] d,
                        output logic [2:0] acks);
    logic a;
    i2c_start();
    wbyte(8'hBA, a); acks[2] = a;
    wbyte(sub, a);   acks[1] = a;
    wbyte(d, a);     acks[0] = a;
    i2c_stop();
  endtask

  task automatic t_reset();
    for (int i = 0; i < NREG; i++) exp_reg[i] = dflt(i);
    chk_regs("R1 defaults");
    chk("R1 sda released", {7'd0, sda_oe}, 8'h00);
  endtask

  task automatic t_write();
    logic [2:0] acks;
    wr_reg(8'h05, 8'h5A, acks); exp_reg[5] = 8'h5A;
    chk("R2 acks", {5'd0, acks}, 8'h07);
    chk_regs("R2 write 05h");
    wr_reg(8'h00, 8'hC3, acks); exp_reg[0] = 8'hC3;
    chk_regs("R2 write 00h");
    chk("R9 idle release", {7'd0, sda_oe}, 8'h00);
  endtask

  task automatic t_mute_region();
    logic [2:0] acks;
    wr_reg(8'h02, 8'h80, acks); exp_reg[2] = 8'h80;
    chk("R7 mute on", {7'd0, mute}, 8'h01);
    wr_reg(8'h02, 8'h7F, acks); exp_reg[2] = 8'h7F;
    chk("R7 mute off", {7'd0, mute}, 8'h00);
    wr_reg(8'h15, 8'h08, acks); exp_reg[21] = 8'h08;
    chk("R8 US code 100", {6'd0, r_us, r_jpn}, 8'h02);
    wr_reg(8'h15, 8'h06, acks); exp_reg[21] = 8'h06;
    chk("R8 JPN code 011", {6'd0, r_us, r_jpn}, 8'h01);
    wr_reg(8'h15, 8'hFE, acks); exp_reg[21] = 8'hFE;
    chk("R8 code 111 neither", {6'd0, r_us, r_jpn}, 8'h00);
  endtask

  task automatic t_bad_addr();
    logic a;
    i2c_start(); wbyte(8'hB8, a); i2c_stop();
    chk("R3 wrong address nack", {7'd0, a}, 8'h00);
    i2c_start(); wbyte(8'h3A, a); wbyte(8'h05, a); wbyte(8'hEE, a); i2c_stop();
    chk_regs("R3 no change");
  endtask

  task automatic t_bad_sub();
    logic [2:0] acks;
    wr_reg(8'h1D, 8'h99, acks);
    chk("R4 sub 1Dh acks", {5'd0, acks}, 8'h04);
    chk_regs("R4 nothing written");
    wr_reg(8'h1C, 8'h07, acks); exp_reg[28] = 8'h07;
    chk("R4 sub 1Ch acks", {5'd0, acks}, 8'h07);
    chk_regs("R4 1Ch written");
  endtask

  task automatic t_extra();
    logic a;
    i2c_start(); wbyte(8'hBA, a); wbyte(8'h03, a); wbyte(8'h11, a);
    wbyte(8'h22, a); chk("R10 extra byte nack", {7'd0, a}, 8'h00);
    wbyte(8'h33, a); i2c_stop();
    exp_reg[3] = 8'h11;
    chk_regs("R10 only 03h written");
  endtask

  task automatic t_read();
    logic a; logic [7:0] b;
    k_off = 1; fm_nd = 0; v_ul = 1; std_nd = 0; a0 = 1; a1 = 0; h_ul = 1;
    i2c_start(); wbyte(8'hBB, a); chk("R5 read ack", {7'd0, a}, 8'h01);
    rbyte(1'b1, b); chk("R5 status A", b, exp_status());
    rbyte(1'b0, b); chk("R5 repeat byte", b, exp_status());
    i2c_stop();
    chk("R9 released after read", {7'd0, sda_oe}, 8'h00);
    k_off = 0; fm_nd = 1; v_ul = 0; std_nd = 1; a0 = 0; a1 = 1; h_ul = 0;
    i2c_start(); wbyte(8'hBB, a); rbyte(1'b0, b); i2c_stop();
    chk("R5 status B, D0 zero", b, exp_status());
  endtask

  task automatic t_shadow();
    logic a; logic [7:0] b, old;
    old = exp_status();
    i2c_start(); wbyte(8'hBB, a);
    k_off = ~k_off; v_ul = ~v_ul; a0 = ~a0; h_ul = ~h_ul;
    rbyte(1'b0, b); i2c_stop();
    chk("R6 captured byte", b, old);
    i2c_start(); wbyte(8'hBB, a); rbyte(1'b0, b); i2c_stop();
    chk("R6 next read new", b, exp_status());
  endtask

  task automatic t_abort();
    logic a;
    i2c_start(); wbyte(8'hBA, a); wbyte(8'h06, a);
    for (int i = 0; i < 4; i++) begin
      sda_m = 1'(i & 1); q(1); scl = 1; q(2); scl = 0; q(1);
    end
    i2c_stop();
    chk_regs("R11 aborted byte");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write();
    t_mute_region();
    t_bad_addr();
    t_bad_sub();
    t_extra();
    t_read();
    t_shadow();
    t_abort();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule